// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fast reference clock into the sixteen-times-oversampling enable tick that a UART transmitter and receiver use. The divisor is a fixed-point number. It has an integer part counted in reference-clock cycles and a fraction counted in sixty-fourths of a cycle. A small accumulator adds the fraction once per tick. Each time the accumulator wraps, the following tick interval is stretched by one reference cycle. Over time the mean tick period therefore equals the programmed divisor exactly.

Software writes the divisor only while the enable input is low. The block captures both divisor fields on the rising edge of enable, and on that same edge it clears its interval counter and its accumulator. While enable is high, the divisor inputs are ignored. An integer part of zero means the generator is stopped. The busy output shows whether ticks are being produced.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted and after it is released with enable low, tick and busy are both 0.
- R2: The integer and fractional divisor inputs are captured only on the clock edge where enable is first seen high. Changes to them while enable stays high do not alter the tick pattern.
- R3: With integer divisor N ≥ 1, the first tick is high in the N-th cycle after the capturing edge. Counting the cycle right after that edge as cycle 0, this is cycle N.
- R4: With fraction F (0..63), the gap from tick k to tick k+1 is N + c_k reference cycles, where c_k = floor(k·F/64) − floor((k−1)·F/64). This means the carry out of the 6-bit accumulator stretches the interval that follows it.
- R5: From the first tick to the sixty-fifth tick, exactly 64·N + F reference cycles pass.
- R6: An integer divisor of 0 captured at the enable edge produces no tick at all, and busy stays 0.
- R7: For N ≥ 2, tick is high for exactly one reference cycle at a time.
- R8: After enable is seen low, tick and busy are 0 from the next cycle on. A later rising edge of enable restarts with the counter and accumulator cleared.
- R9: Busy is 1 from the cycle after the capturing edge, for as long as enable stays high with a nonzero captured integer divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; its rising edge captures the divisor |
| div_int | input | 16 | Integer part of the divisor, in reference cycles |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 cycles |
| tick | output | 1 | One-cycle oversampling enable pulse |
| busy | output | 1 | High while ticks are being generated |

## Verification
The bench builds the block with its default parameters: a 16-bit integer field, a 6-bit fraction, and dithering enabled. Stimulus is kept to integer divisors from 1 to 40. With divisors that small, a full run of 65 ticks stays short. That run walks the accumulator through a complete 64-step wrap, so every carry pattern for the chosen fraction appears. It also checks the exact cumulative sum, which only holds if no carry is lost or duplicated. A divisor of 1, fractions of 0 and 63, and a zero divisor test the edges of the counter compare.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
   // Default field widths of the divisor.
   localparam int DEF_INT_W  = 16;
   localparam int DEF_FRAC_W = 6;
   // Limits checked at elaboration.
   localparam int MIN_INT_W  = 2;
   localparam int MAX_INT_W  = 30;
   localparam int MAX_FRAC_W = 16;

   // Adds one stretch cycle to an integer interval length.
   function automatic logic [MAX_INT_W:0] stretch(input logic [MAX_INT_W-1:0] base,
                                                  input logic                  ext);
      stretch = {1'b0, base} + {{MAX_INT_W{1'b0}}, ext};
   endfunction
endpackage

// File: rtl/bgen_shadow.sv
module bgen_shadow #(
   parameter int INT_W  = bgen_pkg::DEF_INT_W,
   parameter int FRAC_W = bgen_pkg::DEF_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              load,
   output logic              run,
   output logic [INT_W-1:0]  lat_int,
   output logic [FRAC_W-1:0] lat_frac
);
   logic en_q;

   assign load = enable & ~en_q;
   assign run  = enable &  en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         lat_int  <= '0;
         lat_frac <= '0;
      end else begin
         en_q <= enable;
         if (load) begin
            lat_int  <= div_int;
            lat_frac <= div_frac;
         end
      end
   end

   // R2
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(lat_int) && $stable(lat_frac));

   // R2
   load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);
endmodule

// File: rtl/bgen_frac_acc.sv
module bgen_frac_acc #(
   parameter int FRAC_W  = bgen_pkg::DEF_FRAC_W,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   output logic              ext
);
   generate
      if (FRAC_EN) begin : g_dither
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   sum;
         logic              ext_q;

         assign sum = {1'b0, acc} + {1'b0, frac};
         assign ext = ext_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc   <= '0;
               ext_q <= 1'b0;
            end else if (clear) begin
               acc   <= '0;
               ext_q <= 1'b0;
            end else if (step) begin
               acc   <= sum[FRAC_W-1:0];
               ext_q <= sum[FRAC_W];
            end
         end

         // R4
         ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear && !step |=> $stable(ext_q));

         // R8
         acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (acc == '0) && !ext_q);
      end else begin : g_integer
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, clear, step, frac};
         assign ext = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bgen_count.sv
module bgen_count #(
   parameter int INT_W = bgen_pkg::DEF_INT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic [INT_W-1:0] lat_int,
   input  logic             ext,
   output logic             wrap
);
   localparam int CNT_W = INT_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = {1'b0, lat_int} + CNT_W'(ext) - CNT_W'(1);
   assign wrap  = active && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear || !active || wrap)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> cnt <= limit);

   // R4
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == '0);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int INT_W   = bgen_pkg::DEF_INT_W,
   parameter int FRAC_W  = bgen_pkg::DEF_FRAC_W,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick,
   output logic              busy
);
   generate
      if (INT_W < bgen_pkg::MIN_INT_W || INT_W > bgen_pkg::MAX_INT_W) begin : g_bad_int
         $error("baud_tick_gen: INT_W out of range");
      end
      if (FRAC_W < 1 || FRAC_W > bgen_pkg::MAX_FRAC_W) begin : g_bad_frac
         $error("baud_tick_gen: FRAC_W out of range");
      end
   endgenerate

   logic              load;
   logic              run;
   logic [INT_W-1:0]  lat_int;
   logic [FRAC_W-1:0] lat_frac;
   logic              ext;
   logic              wrap;
   logic              active;
   logic              clear;
   logic              tick_q;
   logic              busy_q;

   assign active = run && (lat_int != '0);
   assign clear  = load || !enable;

   bgen_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .div_int  (div_int),
      .div_frac (div_frac),
      .load     (load),
      .run      (run),
      .lat_int  (lat_int),
      .lat_frac (lat_frac)
   );

   bgen_frac_acc #(.FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .step  (wrap),
      .frac  (lat_frac),
      .ext   (ext)
   );

   bgen_count #(.INT_W(INT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .active  (active),
      .lat_int (lat_int),
      .ext     (ext),
      .wrap    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         tick_q <= wrap;
         busy_q <= load ? (div_int != '0) : active;
      end
   end

   assign tick = tick_q;
   assign busy = busy_q;

   // R6
   tick_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> busy_q);

   // R7
   tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q && (lat_int >= INT_W'(2)) |=> !tick_q);

   // R8
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !tick_q && !busy_q);

   // R3
   no_tick_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tick_q);
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [15:0] div_int = '0;
   logic [5:0]  div_frac = '0;
   logic        tick;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   baud_tick_gen u_baud_tick_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .div_int  (div_int),
      .div_frac (div_frac),
      .tick     (tick),
      .busy     (busy)
   );

   function automatic int carry_of(input int f, input int k);
      carry_of = ((k * f) >> 6) - (((k - 1) * f) >> 6);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Drops enable, programs N/F, raises enable and follows 65 ticks.
   task automatic run_case(input int n, input int f, input bit poke);
      int next_exp = n;
      int k = 1;
      int ntick = 0;
      int t1 = -1;
      int t65 = -1;
      bit mism = 0;
      int mc = 0;
      int ma = 0;
      int me = 0;
      bit busy_bad = 0;
      bit wide = 0;
      bit prev = 0;
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      div_int  = 16'(n);
      div_frac = 6'(f);
      enable   = 1'b1;
      @(negedge clk);
      for (int c = 0; c < n * 70 + 100; c++) begin
         bit exp_t = (c == next_exp);
         if (tick !== exp_t && !mism) begin
            mism = 1; mc = c; ma = int'(tick); me = int'(exp_t);
         end
         if (busy !== 1'b1) busy_bad = 1;
         if (tick && prev) wide = 1;
         prev = tick;
         if (tick) begin
            ntick++;
            if (ntick == 1)  t1 = c;
            if (ntick == 65) t65 = c;
         end
         if (exp_t) begin
            next_exp += n + carry_of(f, k);
            k++;
         end
         if (poke && c == 10) begin
            div_int  = 16'($urandom_range(1, 200));
            div_frac = 6'($urandom);
         end
         @(negedge clk);
      end
      if (poke)
         chk(!mism, "R2 pattern after divisor change", ma, me);
      else
         chk(!mism, "R4 tick pattern", ma, me);
      if (mism) $display("  mismatch at cycle %0d for N=%0d F=%0d", mc, n, f);
      chk(t1 == n, "R3 first tick cycle", t1, n);
      chk(t65 - t1 == 64 * n + f, "R5 64-interval sum", t65 - t1, 64 * n + f);
      chk(!busy_bad, "R9 busy while running", int'(!busy_bad), 1);
      if (n >= 2) chk(!wide, "R7 tick width", int'(wide), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      bit any;
      process::self().srandom(32'd7);
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(tick == 1'b0 && busy == 1'b0, "R1 idle after reset", int'({tick, busy}), 0);

      // Directed corners
      run_case(1, 0, 0);
      run_case(1, 63, 0);
      run_case(2, 32, 0);
      run_case(7, 1, 0);
      run_case(16, 0, 0);
      run_case(5, 37, 1);

      // R6 zero divisor
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      div_int = '0; div_frac = 6'd13; enable = 1'b1;
      any = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (tick || busy) any = 1;
      end
      chk(!any, "R6 zero divisor silent", int'(any), 0);

      // R8 stop mid-run, then restart
      enable = 1'b0;
      repeat (2) @(negedge clk);
      div_int = 16'd3; div_frac = '0; enable = 1'b1;
      repeat (10) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(tick == 1'b0 && busy == 1'b0, "R8 stop next cycle", int'({tick, busy}), 0);
      any = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (tick || busy) any = 1;
      end
      chk(!any, "R8 stays stopped", int'(any), 0);
      run_case(4, 20, 0);  // R8 restart from cleared state

      // Random cases
      for (int i = 0; i < 8; i++)
         run_case(int'($urandom_range(1, 40)), int'($urandom_range(0, 63)), 1'(i % 3 == 0));

      summary();
      $finish;
   end
endmodule